// File: doc/BRIEF.md
# Outbound Address Translator

The block maps addresses issued on the processor side into addresses and transaction kinds for a serial expansion link. A small set of programmable windows is held inside it. Each window has a 64-bit base (upper and lower halves), a 32-bit inclusive last-byte limit that shares the base's upper half, a 64-bit target, a 3-bit transaction kind and an enable bit. On every cycle with a request, the block compares the incoming 64-bit address against all windows in parallel. One clock later it presents a hit flag, the translated address and the kind.

Software never addresses a window directly. It first writes a selector register that names a direction and a window number. It then reads or writes that window's fields through one shared group of register offsets. Only the outbound direction is implemented. Selecting the inbound direction, or a window number that does not exist, leaves the shared group dead: reads return zero and writes are dropped. Register reads are combinational from the live window state. A read of the enable register therefore shows the setting the translator already uses, so software can use that read as an ordering fence after programming.

Top module: `out_xlate`

## Requirements
- R1: After reset, every window is disabled, the selector reads 0x00000000, and xl_vld and xl_hit are 0.
- R2: A write to offset 0x900 loads the selector: bit 31 is the direction (1 inbound, 0 outbound) and bits 7:0 are the window number. A read returns those bits with all others 0.
- R3: With an outbound selector naming an existing window, writes and reads at 0x90C/0x910 (base lower/upper), 0x914 (limit), 0x918/0x91C (target lower/upper) hold full 32-bit values. At 0x904 only bits 2:0 (kind) are kept, where memory=0, I/O=2, config type 0=4 and config type 1=5. At 0x908 only bit 31 (enable) is kept. Bits that are not kept read 0.
- R4: With the inbound direction selected, or with a window number at or above NREG, reads of the window offsets return 0 and writes there change no window.
- R5: An address hits an enabled window when {base upper, base lower} <= address <= {base upper, limit}. Both ends are inclusive, so one past the limit, or one below the base, misses.
- R6: On a hit, xl_out is {target upper, target lower} + (address - base), modulo 2^64, and xl_type is the window's kind. Both appear with xl_vld on the cycle after xl_req, so a config window's bus, device and function fields in target bits 31:16 reach the output unchanged for offsets below 64 KiB.
- R7: When several windows hit, the lowest-numbered window supplies the result.
- R8: When no window hits, xl_hit is 0, xl_type is 0 and xl_out equals the requested address.
- R9: A disabled window never hits, whatever its other fields hold.
- R10: A lookup in the same cycle as a register write uses the window settings from before the write. The next lookup uses the new settings, and a read of 0x908 returns the enable that lookups then use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational while cfg_sel is high and cfg_wr is low, else 0 |
| xl_req | input | 1 | Lookup request |
| xl_addr | input | 64 | Address to translate |
| xl_vld | output | 1 | Result valid, one cycle after xl_req |
| xl_hit | output | 1 | A window matched |
| xl_type | output | 3 | Transaction kind of the winning window, 0 on miss |
| xl_out | output | 64 | Translated address, or the input address on miss |

## Verification
Register programming and translation can fall in the same cycle. A write that disables or moves a window can land on the clock edge that captures a lookup aimed at that window. The bench provokes this by driving a control write and a request on the same cycle. It expects the result computed from the old settings, then expects the following lookup to follow the new ones. Around this, seeded random windows, some of them overlapping, are probed at their base, their limit and one step past each end, and every result is compared with a bench model that applies the priority rule.

// File: rtl/out_xlate_pkg.sv
package out_xlate_pkg;
  localparam int ADDR_W   = 64;
  localparam int HALF_W   = 32;
  localparam int DATA_W   = 32;
  localparam int KIND_W   = 3;
  localparam int VP_IDX_W = 8;
  localparam int OFS_W    = 12;

  // register byte offsets seen by software
  localparam logic [OFS_W-1:0] OFS_VIEW  = 12'h900;
  localparam logic [OFS_W-1:0] OFS_CTL1  = 12'h904;
  localparam logic [OFS_W-1:0] OFS_CTL2  = 12'h908;
  localparam logic [OFS_W-1:0] OFS_LBASE = 12'h90C;
  localparam logic [OFS_W-1:0] OFS_UBASE = 12'h910;
  localparam logic [OFS_W-1:0] OFS_LIMIT = 12'h914;
  localparam logic [OFS_W-1:0] OFS_LTGT  = 12'h918;
  localparam logic [OFS_W-1:0] OFS_UTGT  = 12'h91C;

  localparam int EN_BIT  = 31;
  localparam int DIR_BIT = 31;

  // transaction kinds
  localparam logic [KIND_W-1:0] KIND_MEM  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_IO   = 3'd2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 3'd5;

  typedef struct packed {
    logic              en;
    logic [KIND_W-1:0] kind;
    logic [HALF_W-1:0] ubase;
    logic [HALF_W-1:0] lbase;
    logic [HALF_W-1:0] limit;
    logic [HALF_W-1:0] utgt;
    logic [HALF_W-1:0] ltgt;
  } window_t;
endpackage

// File: rtl/out_xlate_rsync.sv
module out_xlate_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;
  logic stage_d;

  always_comb stage_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_core_n <= stage_q;
    end
  end
endmodule

// File: rtl/out_xlate_regs.sv
module out_xlate_regs
  import out_xlate_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_sel,
  input  logic                   cfg_wr,
  input  logic [OFS_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  output window_t [NREG-1:0]     win,
  output logic                   vp_dir,
  output logic [VP_IDX_W-1:0]    vp_idx,
  output logic                   vp_ok
);
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic                wr_str;
  logic                vp_ld;
  logic                vp_dir_d;
  logic [VP_IDX_W-1:0] vp_idx_d;
  window_t             rsel;

  assign wr_str = cfg_sel && cfg_wr;

  // selector register
  always_comb begin
    vp_ld    = wr_str && (cfg_addr == OFS_VIEW);
    vp_dir_d = cfg_wdata[DIR_BIT];
    vp_idx_d = cfg_wdata[VP_IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
    end else if (vp_ld) begin
      vp_dir <= vp_dir_d;
      vp_idx <= vp_idx_d;
    end
  end

  assign vp_ok = !vp_dir && (int'({1'b0, vp_idx}) < NREG);

  // one register set per window
  for (genvar g = 0; g < NREG; g++) begin : g_win
    window_t q;
    window_t d;
    logic    ld;
    logic    hit_sel;

    assign hit_sel = vp_ok && (vp_idx == VP_IDX_W'(g));

    always_comb begin
      d  = q;
      ld = 1'b0;
      if (wr_str && hit_sel) begin
        ld = 1'b1;
        case (cfg_addr)
          OFS_CTL1:  d.kind  = cfg_wdata[KIND_W-1:0];
          OFS_CTL2:  d.en    = cfg_wdata[EN_BIT];
          OFS_LBASE: d.lbase = cfg_wdata;
          OFS_UBASE: d.ubase = cfg_wdata;
          OFS_LIMIT: d.limit = cfg_wdata;
          OFS_LTGT:  d.ltgt  = cfg_wdata;
          OFS_UTGT:  d.utgt  = cfg_wdata;
          default:   ld      = 1'b0;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld) begin
        q <= d;
      end
    end

    assign win[g] = q;
  end

  // read path, straight from live state
  always_comb begin
    rsel = '0;
    if (vp_ok) rsel = win[vp_idx[RIDX_W-1:0]];
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel && !cfg_wr) begin
      case (cfg_addr)
        OFS_VIEW:  cfg_rdata = {vp_dir, {(DATA_W-1-VP_IDX_W){1'b0}}, vp_idx};
        OFS_CTL1:  cfg_rdata = {{(DATA_W-KIND_W){1'b0}}, rsel.kind};
        OFS_CTL2:  cfg_rdata = {rsel.en, {(DATA_W-1){1'b0}}};
        OFS_LBASE: cfg_rdata = rsel.lbase;
        OFS_UBASE: cfg_rdata = rsel.ubase;
        OFS_LIMIT: cfg_rdata = rsel.limit;
        OFS_LTGT:  cfg_rdata = rsel.ltgt;
        OFS_UTGT:  cfg_rdata = rsel.utgt;
        default:   cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/out_xlate_match.sv
module out_xlate_match
  import out_xlate_pkg::*;
#(
  parameter int NREG = 4
) (
  input  window_t [NREG-1:0]              win,
  input  logic [ADDR_W-1:0]               addr,
  output logic [NREG-1:0]                 hit,
  output logic [NREG-1:0][ADDR_W-1:0]     xaddr,
  output logic [NREG-1:0][KIND_W-1:0]     kind
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] tgt;

    assign lo  = {win[g].ubase, win[g].lbase};
    assign hi  = {win[g].ubase, win[g].limit};
    assign tgt = {win[g].utgt, win[g].ltgt};

    assign hit[g]   = win[g].en && (addr >= lo) && (addr <= hi);
    assign xaddr[g] = tgt + (addr - lo);
    assign kind[g]  = win[g].kind;
  end
endmodule

// File: rtl/out_xlate_sel.sv
module out_xlate_sel
  import out_xlate_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            xl_req,
  input  logic [ADDR_W-1:0]               xl_addr,
  input  logic [NREG-1:0]                 hit,
  input  logic [NREG-1:0][ADDR_W-1:0]     xaddr,
  input  logic [NREG-1:0][KIND_W-1:0]     kind,
  output logic                            xl_vld,
  output logic                            xl_hit,
  output logic [KIND_W-1:0]               xl_type,
  output logic [ADDR_W-1:0]               xl_out
);
  logic              win_hit;
  logic [ADDR_W-1:0] win_addr;
  logic [KIND_W-1:0] win_kind;
  logic              vld_d;
  logic              hit_d;

  // lowest index wins: scan from the top down, last assignment sticks
  always_comb begin
    win_hit  = 1'b0;
    win_addr = xl_addr;
    win_kind = KIND_MEM;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_hit  = 1'b1;
        win_addr = xaddr[i];
        win_kind = kind[i];
      end
    end
  end

  always_comb begin
    vld_d = xl_req;
    hit_d = xl_req && win_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_vld <= 1'b0;
      xl_hit <= 1'b0;
    end else begin
      xl_vld <= vld_d;
      xl_hit <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_type <= '0;
      xl_out  <= '0;
    end else if (xl_req) begin
      xl_type <= win_kind;
      xl_out  <= win_addr;
    end
  end
endmodule

// File: rtl/out_xlate.sv
module out_xlate
  import out_xlate_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sel,
  input  logic                cfg_wr,
  input  logic [OFS_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                xl_req,
  input  logic [ADDR_W-1:0]   xl_addr,
  output logic                xl_vld,
  output logic                xl_hit,
  output logic [KIND_W-1:0]   xl_type,
  output logic [ADDR_W-1:0]   xl_out
);
  logic                            rst_core_n;
  window_t [NREG-1:0]              win;
  logic                            vp_dir;
  logic [VP_IDX_W-1:0]             vp_idx;
  logic                            vp_ok;
  logic [NREG-1:0]                 hit;
  logic [NREG-1:0][ADDR_W-1:0]     xaddr;
  logic [NREG-1:0][KIND_W-1:0]     kind;

  out_xlate_rsync i_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  out_xlate_regs #(.NREG(NREG)) i_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win       (win),
    .vp_dir    (vp_dir),
    .vp_idx    (vp_idx),
    .vp_ok     (vp_ok)
  );

  out_xlate_match #(.NREG(NREG)) i_match (
    .win   (win),
    .addr  (xl_addr),
    .hit   (hit),
    .xaddr (xaddr),
    .kind  (kind)
  );

  out_xlate_sel #(.NREG(NREG)) i_sel (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .xl_req  (xl_req),
    .xl_addr (xl_addr),
    .hit     (hit),
    .xaddr   (xaddr),
    .kind    (kind),
    .xl_vld  (xl_vld),
    .xl_hit  (xl_hit),
    .xl_type (xl_type),
    .xl_out  (xl_out)
  );
endmodule

// File: rtl/out_xlate_chk.sv
module out_xlate_chk
  import out_xlate_pkg::*;
(
  input logic                clk,
  input logic                rst_core_n,
  input logic                cfg_sel,
  input logic                cfg_wr,
  input logic [OFS_W-1:0]    cfg_addr,
  input logic [DATA_W-1:0]   cfg_wdata,
  input logic [DATA_W-1:0]   cfg_rdata,
  input logic                xl_req,
  input logic [ADDR_W-1:0]   xl_addr,
  input logic                xl_vld,
  input logic                xl_hit,
  input logic [KIND_W-1:0]   xl_type,
  input logic [ADDR_W-1:0]   xl_out,
  input logic                vp_dir,
  input logic [VP_IDX_W-1:0] vp_idx,
  input logic                vp_ok
);
  // R2: selector captures direction and window number
  a_r2_selector_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_sel && cfg_wr && cfg_addr == OFS_VIEW) |=>
      (vp_dir == $past(cfg_wdata[DIR_BIT]) && vp_idx == $past(cfg_wdata[VP_IDX_W-1:0])));

  // R3: enable register exposes only its top bit
  a_r3_enable_reg_bits: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_sel && !cfg_wr && cfg_addr == OFS_CTL2) |-> (cfg_rdata[DATA_W-2:0] == '0));

  // R4: dead selector makes window reads return zero
  a_r4_dead_window_reads_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_sel && !cfg_wr && !vp_ok && cfg_addr != OFS_VIEW) |-> (cfg_rdata == '0));

  // R6: result follows a request by exactly one cycle
  a_r6_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_core_n)
    xl_req |=> xl_vld);

  // R6: no result without a request
  a_r6_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_core_n)
    !xl_req |=> (!xl_vld && !xl_hit));

  // R8: a miss passes the address through with kind zero
  a_r8_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_core_n)
    (xl_vld && !xl_hit) |-> (xl_type == KIND_MEM && xl_out == $past(xl_addr)));
endmodule

bind out_xlate out_xlate_chk i_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .cfg_sel    (cfg_sel),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .xl_req     (xl_req),
  .xl_addr    (xl_addr),
  .xl_vld     (xl_vld),
  .xl_hit     (xl_hit),
  .xl_type    (xl_type),
  .xl_out     (xl_out),
  .vp_dir     (vp_dir),
  .vp_idx     (vp_idx),
  .vp_ok      (vp_ok)
);

// File: tb/test_out_xlate.sv
module test_out_xlate;
  localparam int NREG = 4;

  logic        clk;
  logic        rst_n;
  logic        cfg_sel;
  logic        cfg_wr;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        xl_req;
  logic [63:0] xl_addr;
  logic        xl_vld;
  logic        xl_hit;
  logic [2:0]  xl_type;
  logic [63:0] xl_out;

  int n_chk;
  int n_err;

  // bench model of window state
  logic        m_en  [NREG];
  logic [2:0]  m_ty  [NREG];
  logic [31:0] m_ub  [NREG];
  logic [31:0] m_lb  [NREG];
  logic [31:0] m_lim [NREG];
  logic [31:0] m_ut  [NREG];
  logic [31:0] m_lt  [NREG];

  out_xlate #(.NREG(NREG)) i_out_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_vld(xl_vld), .xl_hit(xl_hit), .xl_type(xl_type), .xl_out(xl_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    summary();
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {hit, kind, out}
  function automatic logic [67:0] expect_xl(input logic [63:0] a);
    logic [67:0] r;
    logic [63:0] lo;
    logic [63:0] hi;
    r = {1'b0, 3'd0, a};
    for (int i = NREG - 1; i >= 0; i--) begin
      lo = {m_ub[i], m_lb[i]};
      hi = {m_ub[i], m_lim[i]};
      if (m_en[i] && a >= lo && a <= hi)
        r = {1'b1, m_ty[i], {m_ut[i], m_lt[i]} + (a - lo)};
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
    #1;
    d = cfg_rdata;
    cfg_sel = 1'b0;
  endtask

  task automatic look(input logic [63:0] a, input string tag);
    logic [67:0] e;
    e = expect_xl(a);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
    chk(tag, {59'd0, xl_vld, xl_hit, xl_type, xl_out}, {59'd0, 1'b1, e});
  endtask

  task automatic prog(input int idx, input logic en, input logic [2:0] ty,
                      input logic [31:0] ub, input logic [31:0] lb, input logic [31:0] lim,
                      input logic [31:0] ut, input logic [31:0] lt);
    cfg_write(12'h900, idx);
    cfg_write(12'h908, 32'h0);
    cfg_write(12'h90C, lb);
    cfg_write(12'h910, ub);
    cfg_write(12'h914, lim);
    cfg_write(12'h918, lt);
    cfg_write(12'h91C, ut);
    cfg_write(12'h904, {29'd0, ty});
    cfg_write(12'h908, {en, 31'd0});
    m_en[idx] = en; m_ty[idx] = ty; m_ub[idx] = ub; m_lb[idx] = lb;
    m_lim[idx] = lim; m_ut[idx] = ut; m_lt[idx] = lt;
  endtask

  initial begin
    logic [31:0] rd;
    logic [67:0] e;
    logic [63:0] a;
    n_chk = 0; n_err = 0;
    cfg_sel = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    xl_req = 0; xl_addr = 0;
    for (int i = 0; i < NREG; i++) begin
      m_en[i] = 0; m_ty[i] = 0; m_ub[i] = 0; m_lb[i] = 0;
      m_lim[i] = 0; m_ut[i] = 0; m_lt[i] = 0;
    end
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 vld/hit after reset", {126'd0, xl_vld, xl_hit}, 128'd0);
    cfg_read(12'h900, rd);
    chk("R1 selector after reset", rd, 0);
    cfg_read(12'h908, rd);
    chk("R1 window 0 enable after reset", rd, 0);
    // R9: all disabled, every lookup misses
    look(64'h0, "R9 reset miss at zero");
    look(64'h0000_0001_0000_1000, "R9 reset miss");

    // R2: selector readback, masking
    cfg_write(12'h900, 32'h8000_7F03);
    cfg_read(12'h900, rd);
    chk("R2 selector readback", rd, 32'h8000_0003);

    // R3: field readback and masking
    cfg_write(12'h900, 32'h2);
    cfg_write(12'h90C, 32'hDEAD_BEE0);
    cfg_read(12'h90C, rd);
    chk("R3 base lower readback", rd, 32'hDEAD_BEE0);
    cfg_write(12'h91C, 32'h1234_5678);
    cfg_read(12'h91C, rd);
    chk("R3 target upper readback", rd, 32'h1234_5678);
    cfg_write(12'h904, 32'hFFFF_FFFD);
    cfg_read(12'h904, rd);
    chk("R3 kind masked", rd, 32'h5);
    cfg_write(12'h908, 32'h7FFF_FFFF);
    cfg_read(12'h908, rd);
    chk("R3 enable masked off", rd, 32'h0);
    cfg_write(12'h904, 32'h0);
    cfg_write(12'h90C, 32'h0);
    cfg_write(12'h91C, 32'h0);

    // R4: invalid index and inbound direction
    cfg_write(12'h900, NREG);
    cfg_write(12'h90C, 32'hAAAA_5555);
    cfg_read(12'h90C, rd);
    chk("R4 out-of-range read zero", rd, 0);
    cfg_write(12'h900, 32'h8000_0001);
    cfg_write(12'h908, 32'h8000_0000);
    cfg_write(12'h914, 32'hFFFF_FFFF);
    cfg_read(12'h914, rd);
    chk("R4 inbound read zero", rd, 0);
    cfg_write(12'h900, 32'h1);
    cfg_read(12'h908, rd);
    chk("R4 inbound write ignored", rd, 0);
    cfg_read(12'h914, rd);
    chk("R4 inbound limit write ignored", rd, 0);
    cfg_write(12'h900, 32'h0);
    cfg_read(12'h90C, rd);
    chk("R4 out-of-range write ignored", rd, 0);

    // R5/R6: boundaries on an I/O window
    prog(1, 1'b1, 3'd2, 32'h1, 32'h0000_1000, 32'h0000_1FFF, 32'h20, 32'h0);
    look(64'h0000_0001_0000_0FFF, "R5 below base misses");
    look(64'h0000_0001_0000_1000, "R5 base hits");
    look(64'h0000_0001_0000_1FFF, "R5 limit hits");
    look(64'h0000_0001_0000_2000, "R5 past limit misses");
    look(64'h0000_0002_0000_1800, "R5 other upper misses");
    look(64'h0000_0001_0000_1234, "R6 io translate");

    // R6: config target fields reach output
    prog(3, 1'b1, 3'd4, 32'h0, 32'h4000_0000, 32'h4000_FFFF, 32'h0,
         {8'h03, 5'h1F, 3'h2, 16'h0});
    look(64'h0000_0000_4000_0044, "R6 config window");
    chk("R6 bus/dev/fn fields", {112'd0, xl_out[31:16]}, {112'd0, 8'h03, 5'h1F, 3'h2});
    chk("R6 config kind", xl_type, 3'd4);

    // R7: overlap, lower index wins
    prog(2, 1'b1, 3'd5, 32'h0, 32'h4000_0000, 32'h4000_0FFF, 32'h0, 32'h0);
    prog(0, 1'b1, 3'd0, 32'h0, 32'h4000_0800, 32'h4000_08FF, 32'h9, 32'h9000_0000);
    look(64'h0000_0000_4000_0810, "R7 index 0 over 2 and 3");
    chk("R7 winner kind", xl_type, 3'd0);
    look(64'h0000_0000_4000_0100, "R7 index 2 over 3");
    chk("R7 second winner kind", xl_type, 3'd5);

    // R9: disabled window never hits
    prog(0, 1'b0, 3'd0, 32'h0, 32'h4000_0800, 32'h4000_08FF, 32'h9, 32'h9000_0000);
    look(64'h0000_0000_4000_0810, "R9 disabled window skipped");

    // R10: write and lookup in one cycle
    cfg_write(12'h900, 32'h1);
    a = 64'h0000_0001_0000_1400;
    e = expect_xl(a);
    @(negedge clk);
    cfg_sel = 1; cfg_wr = 1; cfg_addr = 12'h908; cfg_wdata = 32'h0;
    xl_req = 1; xl_addr = a;
    @(negedge clk);
    cfg_sel = 0; cfg_wr = 0; xl_req = 0;
    chk("R10 same-cycle uses old settings", {59'd0, xl_vld, xl_hit, xl_type, xl_out}, {59'd0, 1'b1, e});
    m_en[1] = 1'b0;
    cfg_read(12'h908, rd);
    chk("R10 enable read shows new value", rd, 0);
    look(a, "R10 next lookup uses new settings");
    cfg_write(12'h908, 32'h8000_0000);
    m_en[1] = 1'b1;
    cfg_read(12'h908, rd);
    chk("R10 enable read after re-enable", rd, 32'h8000_0000);
    look(a, "R10 fence then lookup hits");

    // random windows and probes
    for (int it = 0; it < 300; it++) begin
      int r;
      int k;
      logic [31:0] lb;
      logic [31:0] sz;
      logic [63:0] lo;
      logic [63:0] hi;
      if ((it % 10) == 0) begin
        r  = $urandom_range(0, NREG - 1);
        lb = $urandom & 32'hFFFF_F000;
        sz = $urandom_range(1, 32'h0001_0000);
        prog(r, ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 5)),
             32'($urandom_range(0, 1)), lb, lb + sz, $urandom, $urandom);
      end
      r  = $urandom_range(0, NREG - 1);
      lo = {m_ub[r], m_lb[r]};
      hi = {m_ub[r], m_lim[r]};
      k  = $urandom_range(0, 5);
      case (k)
        0: a = lo;
        1: a = hi;
        2: a = lo - 64'd1;
        3: a = hi + 64'd1;
        4: a = lo + 64'($urandom_range(0, 255));
        default: a = {32'($urandom_range(0, 1)), $urandom};
      endcase
      look(a, "R5 R6 R7 R8 random probe");
    end

    // R8: clear miss far away
    look(64'hFFFF_FFFF_FFFF_FFF0, "R8 far miss passthrough");

    summary();
  end
endmodule